// File: doc/BRIEF.md
# Serial Four-Bit Even-Parity Generator

This block takes a serial data stream, one bit per clock, and works out the even-parity bit for every group of four bits it accepts. A bit counts as accepted only on a cycle where its qualifying strobe is high, so the source may leave gaps inside a group. When the fourth bit of a group has been taken, the block raises a parity strobe for exactly one cycle. During that cycle the parity output carries the bit that makes the count of ones even, counting the four data bits and the parity bit together. The block then returns to its start state and is ready for the next group, with no reset needed.

Inside, a single state register holds nine codes. Code 0 is the start state. Every other code joins the number of bits taken so far with the running parity. The code for level L (1 to 4) and odd flag p is 2L-1+p, so codes 7 and 8 are the even and odd parity cycles. A code outside 0 to 8 is sent back to 0 on the next clock, so the machine cannot lock out. The block supplies only the parity bit and its timing. Building the outgoing frame is left to the surrounding logic.

Top module: `par4_gen`

## Requirements
- R1: While synchronous reset is high at a rising clock edge, both outputs are 0 after that edge.
- R2: A data bit is taken only on an edge where `ser_vld` is 1. Cycles with `ser_vld` low, including ones in the middle of a group, change neither the count nor the parity.
- R3: `par_vld` goes high in the cycle that follows the clock edge at which the fourth bit of a group is taken, and at no other time.
- R4: While `par_vld` is 1, `par_bit` equals the XOR of the four accepted data bits. A group with an odd number of ones gives 1, and a group with an even number gives 0.
- R5: `par_vld` stays high for exactly one cycle. The next bit taken after that cycle is the first bit of a new group, with no reset in between.
- R6: Data presented with `ser_vld` high during the parity cycle is ignored. It belongs to no group.
- R7: `par_bit` is 0 whenever `par_vld` is 0.
- R8: A reset in the middle of a group throws away the bits already taken. The next four accepted bits form a complete group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_bit | input | 1 | Serial data bit |
| ser_vld | input | 1 | Qualifies `ser_bit` for the current cycle |
| par_bit | output | 1 | Even-parity bit, valid while `par_vld` is high |
| par_vld | output | 1 | One-cycle strobe that marks the parity cycle |

## Verification
Emitting the parity bit and receiving a data bit can fall in the same cycle. A source that streams without pause puts a valid bit on the wire during the parity cycle. The bench provokes this by running all sixteen patterns back to back, and by random gaps that keep `ser_vld` high through the strobe. It judges the result by checking that the strobe lasts exactly one cycle, and that the following group's parity matches a reference that drops the overlapping bit. Reset landing on a strobe cycle, or in the middle of a group, is also driven. The bench then checks that the outputs clear and that a fresh group of four follows.

// File: rtl/par4_pkg.sv
package par4_pkg;

    // Width of a state code able to hold 2*grp+1 distinct values.
    function automatic int unsigned st_width(input int unsigned grp);
        return $clog2(2 * grp + 1);
    endfunction

endpackage

// File: rtl/par4_step.sv
module par4_step #(
    parameter int unsigned GRP = 4,
    parameter int unsigned STW = par4_pkg::st_width(GRP)
) (
    input  logic [STW-1:0] st,
    input  logic           take,
    input  logic           din,
    output logic [STW-1:0] nxt
);
    localparam logic [STW-1:0] LAST_CODE = STW'(2 * GRP);
    localparam logic [STW-1:0] TOP_LVL   = STW'(GRP);

    logic [STW-1:0] lvl;
    logic [STW-1:0] nlvl;
    logic           odd;
    logic           nodd;

    always_comb begin
        lvl  = STW'((st + STW'(1)) >> 1);
        odd  = (st != '0) && !st[0];
        nlvl = lvl + STW'(1);
        nodd = odd ^ din;
        if (st > LAST_CODE) begin
            nxt = '0;                       // unused code: back to start
        end else if (lvl == TOP_LVL) begin
            nxt = '0;                       // parity cycle: restart
        end else if (take) begin
            nxt = STW'((nlvl << 1) - STW'(1) + STW'(nodd));
        end else begin
            nxt = st;
        end
    end
endmodule

// File: rtl/par4_decode.sv
module par4_decode #(
    parameter int unsigned GRP = 4,
    parameter int unsigned STW = par4_pkg::st_width(GRP)
) (
    input  logic [STW-1:0] st,
    output logic           vld,
    output logic           par
);
    localparam logic [STW-1:0] EVEN_END = STW'(2 * GRP - 1);
    localparam logic [STW-1:0] ODD_END  = STW'(2 * GRP);

    always_comb begin
        vld = (st == EVEN_END) || (st == ODD_END);
        par = (st == ODD_END);
    end
endmodule

// File: rtl/par4_gen.sv
module par4_gen #(
    parameter int unsigned GRP = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_bit,
    input  logic ser_vld,
    output logic par_bit,
    output logic par_vld
);
    localparam int unsigned STW = par4_pkg::st_width(GRP);

    typedef struct packed {
        logic [STW-1:0] st;
        logic           vld;
        logic           par;
    } regs_t;

    regs_t          r_d;
    regs_t          r_q;
    logic [STW-1:0] st_nxt;
    logic           dec_vld;
    logic           dec_par;

    par4_step #(.GRP(GRP), .STW(STW)) u_step (
        .st   (r_q.st),
        .take (ser_vld),
        .din  (ser_bit),
        .nxt  (st_nxt)
    );

    par4_decode #(.GRP(GRP), .STW(STW)) u_dec (
        .st  (st_nxt),
        .vld (dec_vld),
        .par (dec_par)
    );

    always_comb begin
        r_d     = r_q;
        r_d.st  = st_nxt;
        r_d.vld = dec_vld;
        r_d.par = dec_par;
        if (rst) begin
            r_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign par_bit = r_q.par;
    assign par_vld = r_q.vld;
endmodule

// File: rtl/par4_gen_chk.sv
module par4_gen_chk #(
    parameter int unsigned GRP = 4
) (
    input logic clk,
    input logic rst,
    input logic ser_bit,
    input logic ser_vld,
    input logic par_bit,
    input logic par_vld
);
    localparam int unsigned CW = $clog2(GRP + 1);

    logic [CW-1:0] cnt;
    logic          acc;

    // Independent tally of accepted bits and their XOR.
    always_ff @(posedge clk) begin
        if (rst || par_vld) begin
            cnt <= '0;
            acc <= 1'b0;
        end else if (ser_vld) begin
            cnt <= cnt + CW'(1);
            acc <= acc ^ ser_bit;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!par_vld && !par_bit));

    a_r2_no_take_no_strobe: assert property (@(posedge clk) disable iff (rst)
        (!ser_vld && !par_vld) |=> !par_vld);

    a_r3_strobe_at_count: assert property (@(posedge clk) disable iff (rst)
        (cnt == CW'(GRP)) == par_vld);

    a_r4_parity_value: assert property (@(posedge clk) disable iff (rst)
        par_vld |-> (par_bit == acc));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        par_vld |=> !par_vld);

    a_r7_quiet_bit: assert property (@(posedge clk) disable iff (rst)
        !par_vld |-> !par_bit);
endmodule

bind par4_gen par4_gen_chk #(.GRP(GRP)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ser_bit (ser_bit),
    .ser_vld (ser_vld),
    .par_bit (par_bit),
    .par_vld (par_vld)
);

// File: tb/par4_gen_tb.sv
`timescale 1ns/1ps
module par4_gen_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_bit = 1'b0;
    logic ser_vld = 1'b0;
    logic par_bit;
    logic par_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench reference
    int cnt = 0;
    bit acc = 1'b0;
    bit ev  = 1'b0;
    bit ep  = 1'b0;

    always #2.5 clk = ~clk;

    par4_gen u_dut (
        .clk(clk), .rst(rst), .ser_bit(ser_bit), .ser_vld(ser_vld),
        .par_bit(par_bit), .par_vld(par_vld)
    );

    function automatic bit xor4(input logic [3:0] v);
        return v[0] ^ v[1] ^ v[2] ^ v[3];
    endfunction

    task automatic check(input string tag, input bit xv, input bit xp);
        n_chk++;
        if (par_vld !== xv || par_bit !== xp) begin
            n_bad++;
            $display("FAIL %s: vld=%0b par=%0b expected vld=%0b par=%0b",
                     tag, par_vld, par_bit, xv, xp);
        end
    endtask

    // One clock: drive at negedge, advance reference at posedge, compare after.
    task automatic step(input bit r, input bit v, input bit d, input string tag);
        @(negedge clk);
        rst = r; ser_vld = v; ser_bit = d;
        @(posedge clk);
        if (r) begin
            cnt = 0; acc = 0; ev = 0; ep = 0;
        end else if (ev) begin
            cnt = 0; acc = 0; ev = 0; ep = 0;
        end else if (v) begin
            acc = acc ^ d;
            cnt++;
            if (cnt == 4) begin ev = 1; ep = acc; end
        end
        #1;
        check(tag, ev, ep);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: vld=%0b par=%0b expected vld=%0b par=%0b",
                     par_vld, par_bit, 1'b0, 1'b0);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        // R1: reset state
        repeat (3) step(1, 1, 1, "R1");

        // R4 R6: every pattern back to back; the strobe cycle carries valid data
        for (int p = 0; p < 16; p++) begin
            for (int i = 0; i < 4; i++) step(0, 1, p[i], "R4");
            n_chk++;
            if (par_bit !== xor4(p[3:0])) begin
                n_bad++;
                $display("FAIL R4: par=%0b expected par=%0b", par_bit, xor4(p[3:0]));
            end
            step(0, 1, $urandom_range(1), "R6");
        end

        // R3: strobe only after the fourth bit
        step(0, 1, 1, "R3"); step(0, 1, 0, "R3"); step(0, 1, 1, "R3");
        step(0, 0, 1, "R3"); step(0, 1, 1, "R3"); step(0, 0, 0, "R5");
        step(0, 0, 0, "R5");

        // R7: idle with data high
        repeat (4) step(0, 0, 1, "R7");

        // R6 R5: ones during the strobe cycle must not leak into next group
        for (int i = 0; i < 4; i++) step(0, 1, 1'(i == 0), "R5");
        step(0, 1, 1, "R6");
        for (int i = 0; i < 4; i++) step(0, 1, 0, "R6");
        step(0, 0, 0, "R6");

        // R8: reset in the middle of a group, then a clean group
        step(0, 1, 1, "R8"); step(0, 1, 1, "R8"); step(0, 1, 1, "R8");
        step(1, 1, 1, "R8");
        step(0, 1, 1, "R8"); step(0, 1, 0, "R8"); step(0, 1, 0, "R8");
        step(0, 1, 0, "R8"); step(0, 0, 0, "R8");

        // R1: reset landing on a strobe cycle
        for (int i = 0; i < 4; i++) step(0, 1, 1, "R1");
        step(1, 1, 1, "R1");
        step(0, 0, 0, "R1");

        // R2: random gaps and data
        for (int k = 0; k < 600; k++) begin
            step(($urandom_range(99) == 0), ($urandom_range(2) != 0),
                 $urandom_range(1), "R2");
        end

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule